// File: doc/BRIEF.md
# Extended-Range Branch and Index Unit

This block sequences the program counter of a small processor core whose instructions carry 9-bit register fields while its local memory holds more than 512 words. Register operands and immediate jump targets can name only the low 512 words. Code above that line is reached in one of three ways. The first is an indirect jump whose target is fetched from a register. The second uses the two flag-write-enable bits of a jump as extra target address bits. The third places the current hardware task's ID in the upper address bits. Data above word 511 is reached by treating any low register as an index register.

Each cycle the unit takes one decoded instruction. For register-sourced operations it presents a read address to the local memory's asynchronous read port and takes the returned word in the same cycle. A call also drives a write to the link register with the return address. The program counter is registered and updates at the next clock edge. The ALU, the memory array and the instruction decoder sit outside the block.

Top module: `xbranch_unit`

## Requirements
- R1: While `rst_n` is low and after it rises, `pc` is 0 until the first valid instruction is executed.
- R2: A valid instruction of class 0 (plain) or class 3 (index) advances `pc` by one, and the count wraps from 2047 to 0. A cycle with `instr_valid` low leaves `pc` unchanged.
- R3: In mode 0 (indirect scheme), an immediate jump (class 1) loads `pc` with `src_field` zero-extended, so the target stays within words 0 to 511.
- R4: A non-immediate jump or call reads the register named by `src_field` through `rd_addr` and loads `pc` with the low 11 bits of `rd_data`. The upper data bits are discarded.
- R5: In mode 1 (flag-bit scheme), an immediate jump or call loads `pc` with {`fc_we`, `fz_we`, `src_field`}, where `fc_we` is bit 10 and `fz_we` is bit 9.
- R6: In mode 2 (task scheme), immediate targets and register read addresses are {`task_id`, `src_field`}, so each task has its own 512-word window.
- R7: A valid call (class 2) asserts `wr_en` in the same cycle. It drives `wr_data` with the return address `pc`+1, wrapped to 11 bits and zero-extended. It drives `wr_addr` with the link register (word 496) inside the active window. No other cycle asserts `wr_en`.
- R8: A valid index operation (class 3) asserts `ea_valid` and drives `ea_addr` with the low 11 bits of the word read from the register named by `src_field`.
- R9: Mode 3 behaves exactly like mode 0.
- R10: Outside mode 1 the flag-write bits have no effect on the target. Outside mode 2 `task_id` has no effect on targets or register addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Far-reach scheme: 0 indirect, 1 flag bits, 2 task window, 3 as 0 |
| instr_valid | input | 1 | An instruction executes this cycle |
| op_class | input | 2 | 0 plain, 1 jump, 2 call, 3 index access |
| imm_flag | input | 1 | Target taken from `src_field` rather than from a register |
| fz_we | input | 1 | Zero-flag write enable; extra target bit 9 in mode 1 |
| fc_we | input | 1 | Carry-flag write enable; extra target bit 10 in mode 1 |
| src_field | input | 9 | Source field of the instruction |
| dst_field | input | 9 | Destination field (not used for sequencing) |
| task_id | input | 2 | Current hardware task |
| rd_data | input | 32 | Word returned from `rd_addr` in the same cycle |
| rd_addr | output | 11 | Memory read address for the source register |
| wr_en | output | 1 | Link register write strobe |
| wr_addr | output | 11 | Link register address |
| wr_data | output | 32 | Return address |
| ea_valid | output | 1 | Index effective address is valid |
| ea_addr | output | 11 | Effective address from the index register |
| pc | output | 11 | Program counter |

## Verification
The bench drives every 9-bit source value through each of the four modes. It sets the flag bits and the task ID from the source bits, so a design that mixed the extra bits into the wrong scheme, swapped the two flag bits, or let mode 3 decode differently would land on the wrong word. For register-sourced jumps it fills the upper data bits with ones, which catches a design that fails to truncate the fetched target. Calls are checked for a return address one past the call, for the link address inside the task window, and for the return address wrapping at the top of memory. A jump to word 2047 followed by a plain step exposes a counter that does not wrap, and idle cycles expose a counter that advances without a valid instruction.

// File: rtl/xbranch_unit.sv
module xbranch_unit #(
  parameter int PC_W    = 11,
  parameter int FIELD_W = 9,
  parameter int DATA_W  = 32,
  parameter int LINK_REG = 496
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               instr_valid,
  input  logic [1:0]         op_class,
  input  logic               imm_flag,
  input  logic               fz_we,
  input  logic               fc_we,
  input  logic [FIELD_W-1:0] src_field,
  input  logic [FIELD_W-1:0] dst_field,
  input  logic [1:0]         task_id,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [PC_W-1:0]    rd_addr,
  output logic               wr_en,
  output logic [PC_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               ea_valid,
  output logic [PC_W-1:0]    ea_addr,
  output logic [PC_W-1:0]    pc
);
  localparam int XW = FIELD_W + 2;
  localparam logic [FIELD_W-1:0] LINK = FIELD_W'(LINK_REG);

  logic [PC_W-1:0] pc_q, pc_inc, imm_tgt, ind_tgt, nxt;
  logic [1:0]      tgt_up, win_up;
  logic            is_br, unused_ok;

  assign unused_ok = ^dst_field;

  always_comb begin
    case (mode)
      2'd1:    tgt_up = {fc_we, fz_we};
      2'd2:    tgt_up = task_id;
      default: tgt_up = 2'b00;
    endcase
  end

  assign win_up  = (mode == 2'd2) ? task_id : 2'b00;
  assign rd_addr = PC_W'({win_up, src_field});
  assign wr_addr = PC_W'({win_up, LINK});

  assign is_br   = (op_class == 2'd1) || (op_class == 2'd2);
  assign pc_inc  = pc_q + PC_W'(1);
  assign imm_tgt = PC_W'({tgt_up, src_field});
  assign ind_tgt = rd_data[PC_W-1:0];

  assign wr_en    = instr_valid && (op_class == 2'd2);
  assign wr_data  = DATA_W'(pc_inc);
  assign ea_valid = instr_valid && (op_class == 2'd3);
  assign ea_addr  = rd_data[PC_W-1:0];

  always_comb begin
    nxt = pc_q;
    if (instr_valid) begin
      if (is_br) nxt = imm_flag ? imm_tgt : ind_tgt;
      else       nxt = pc_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= nxt;
  end

  assign pc = pc_q;

  logic [XW-1:0] xw_unused;
  assign xw_unused = '0;

  assert_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !is_br |=> pc_q == PC_W'($past(pc_q) + PC_W'(1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(pc_q));

  assert_ind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && is_br && !imm_flag |=> pc_q == $past(rd_data[PC_W-1:0]));

  assert_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && is_br && imm_flag && (mode == 2'd0 || mode == 2'd3)
      |=> pc_q[PC_W-1:FIELD_W] == '0);

  assert_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && is_br && imm_flag |=> pc_q[FIELD_W-1:0] == $past(src_field));

  assert_task_R6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && is_br && imm_flag && mode == 2'd2
      |=> pc_q[FIELD_W+1:FIELD_W] == $past(task_id));

  assert_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> instr_valid && op_class == 2'd2 && !ea_valid);
endmodule

// File: tb/xbranch_unit_tb.sv
module xbranch_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  mode = 0, op_class = 0, task_id = 0;
  logic        instr_valid = 0, imm_flag = 0, fz_we = 0, fc_we = 0;
  logic [8:0]  src_field = 0, dst_field = 0;
  logic [31:0] rd_data = 0;
  logic [10:0] rd_addr, wr_addr, ea_addr, pc;
  logic        wr_en, ea_valid;
  logic [31:0] wr_data;

  int checks = 0, errors = 0;
  int mpc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xbranch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .instr_valid(instr_valid),
    .op_class(op_class), .imm_flag(imm_flag), .fz_we(fz_we), .fc_we(fc_we),
    .src_field(src_field), .dst_field(dst_field), .task_id(task_id),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ea_valid(ea_valid), .ea_addr(ea_addr), .pc(pc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input int op, input bit imm, input bit fz, input bit fc,
                      input int src, input int md, input int tk, input int rdv, input string req);
    int up, win, nxt;
    @(negedge clk);
    instr_valid = v; op_class = 2'(op); imm_flag = imm; fz_we = fz; fc_we = fc;
    src_field = 9'(src); dst_field = 9'(~src); mode = 2'(md); task_id = 2'(tk);
    rd_data = 32'(rdv);
    #2;
    up  = (md == 1) ? fc * 2 + fz : (md == 2) ? tk : 0;
    win = (md == 2) ? tk : 0;
    chk(int'(rd_addr) == win * 512 + src, {req, " rd_addr"}, int'(rd_addr), win * 512 + src);
    chk(wr_en == (v && op == 2), "R7 wr_en", int'(wr_en), int'(v && op == 2));
    if (v && op == 2) begin
      chk(int'(wr_addr) == win * 512 + 496, "R7 wr_addr", int'(wr_addr), win * 512 + 496);
      chk(wr_data == 32'((mpc + 1) % 2048), "R7 wr_data", int'(wr_data), (mpc + 1) % 2048);
    end
    chk(ea_valid == (v && op == 3), "R8 ea_valid", int'(ea_valid), int'(v && op == 3));
    if (v && op == 3)
      chk(int'(ea_addr) == (rdv & 2047), "R8 ea_addr", int'(ea_addr), rdv & 2047);
    nxt = mpc;
    if (v) begin
      if (op == 1 || op == 2) nxt = imm ? up * 512 + src : (rdv & 2047);
      else nxt = (mpc + 1) % 2048;
    end
    mpc = nxt;
    @(posedge clk); #2;
    chk(int'(pc) == mpc, {req, " pc"}, int'(pc), mpc);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 chk(pc == 0, "R1 pc in reset", int'(pc), 0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #2 chk(pc == 0, "R1 pc after reset", int'(pc), 0);

    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, i, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 1, 300, 1, 3, 0, "R2 idle");

    for (int md = 0; md < 4; md++)
      for (int s = 0; s < 512; s++)
        step(1, 1, 1, s[0], s[1], s, md, s[3:2], 0,
             md == 0 ? "R10 R3" : md == 1 ? "R5" : md == 2 ? "R6" : "R9");

    for (int s = 0; s < 512; s += 7)
      step(1, 1, 0, 1, 1, s, s % 4, s % 4, 32'hFFFF_F800 | (s * 4), "R4");

    for (int s = 0; s < 512; s += 5)
      step(1, 2, s[0], s[1], s[2], s, s % 4, s[4:3], s * 3, "R7");

    for (int s = 0; s < 64; s++)
      step(1, 3, 0, 0, 0, s, s % 3, s % 4, 32'h5A5A_0000 + s * 37, "R8");

    step(1, 1, 1, 1, 1, 511, 1, 0, 0, "R5 top");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 wrap");
    step(1, 1, 1, 1, 1, 511, 1, 0, 0, "R5 top");
    step(1, 2, 1, 0, 0, 5, 0, 0, 0, "R7 wrap");
    step(0, 0, 0, 0, 0, 0, 2, 1, 0, "R2 idle");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule